// File: doc/BRIEF.md
# Load Queue with Store Ordering Check

This block holds the loads that an out-of-order core has dispatched but not yet committed. Each load takes a slot at dispatch, tagged with its sequence number, and gets its effective address written when it executes. Loads leave in age order when commit reports the youngest committed sequence number. A squash drops every load younger than a given sequence number in one cycle.

When a store executes, the queue compares the store against all loads younger than it that already have an address. If one of them used the same 256-byte region as the store, that load read stale data. The oldest such load is latched as the violator and held until the core acknowledges it. The queue also tells dispatch how many load/store pairs still fit, using a store free count supplied by the store queue.

Top module: `load_queue`

## Requirements
- R1: After reset the queue is empty (count_o = 0), lq_full_o is 0 and viol_valid_o is 0.
- R2: An allocate writes the load into slot alloc_idx_o, then alloc_idx_o moves to the next slot modulo DEPTH and count_o rises by one. When count_o equals DEPTH, lq_full_o is 1 and an allocate is ignored.
- R3: A commit retires in one cycle every load, oldest first, whose sequence number is at or below commit_seq_i. Retiring stops at the first load above that value. oldest_seq_o then shows the new oldest load.
- R4: A squash removes in one cycle every load whose sequence number is greater than squash_seq_i, and alloc_idx_o steps back by the same count. In a cycle with a squash, allocate and commit are ignored.
- R5: A store check that finds a live, younger load with a written address matches when both addresses agree in bits ADDR_W-1..8. One cycle later viol_valid_o is 1, with that load's slot on viol_idx_o and its sequence number on viol_seq_o.
- R6: During a store check, no match is made for any of these loads: a load whose sequence number is at or below the store's, a load whose address has not been written, or a load in a different 256-byte region.
- R7: If several loads match, the one reported is the oldest, counted from the oldest live slot and following wraparound of the slot index.
- R8: While viol_valid_o is 1, a store check is ignored and the report stays unchanged. viol_ack_i clears viol_valid_o one cycle later, and a check in that same cycle is ignored.
- R9: disp_free_o equals min(DEPTH - count_o, sq_free_i) - 1, and is 0 when that minimum is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Allocate a load at dispatch |
| alloc_seq_i | input | SEQ_W | Sequence number of the new load |
| alloc_idx_o | output | IDX_W | Slot the next allocate will use |
| lq_full_o | output | 1 | All slots in use |
| exec_valid_i | input | 1 | Write a load's effective address |
| exec_idx_i | input | IDX_W | Slot of the executing load |
| exec_addr_i | input | ADDR_W | Effective address |
| commit_valid_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Loads above this are removed |
| st_valid_i | input | 1 | Store ordering check |
| st_seq_i | input | SEQ_W | Store sequence number |
| st_addr_i | input | ADDR_W | Store effective address |
| viol_valid_o | output | 1 | Violator latched |
| viol_idx_o | output | IDX_W | Slot of the violating load |
| viol_seq_o | output | SEQ_W | Sequence number of the violating load |
| viol_ack_i | input | 1 | Violator read; clears it |
| sq_free_i | input | CNT_W | Free store slots |
| disp_free_o | output | CNT_W | Free pairs reported to dispatch |
| count_o | output | CNT_W | Live loads |
| oldest_seq_o | output | SEQ_W | Sequence number of the oldest load |

## Verification
The hardest case to reach is a set of several matching younger loads that lie across the wrap point of the slot index, where the oldest match sits at a higher slot number than a younger match. The stimulus gets there in steps. It commits and squashes until the head sits mid-array, then fills the queue so the tail wraps. It then writes same-region addresses into slots on both sides of the wrap. A second hard case is a store check while a report is pending that would otherwise match. The bench issues one before the acknowledge and one in the acknowledge cycle, then checks that the report held is the first one.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic [1:0] {
    LQ_HOLD   = 2'd0,
    LQ_COMMIT = 2'd1,
    LQ_SQUASH = 2'd2
  } lq_op_e;
endpackage

// File: rtl/lq_live.sv
// Per-slot liveness from head pointer and occupancy.
module lq_live #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [DEPTH-1:0] live_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [IDX_W-1:0] rel;
    assign rel       = IDX_W'(i) - head_i;
    assign live_o[i] = {1'b0, rel} < count_i;
  end
endmodule

// File: rtl/lq_tally.sv
// Counts loads eligible for commit and for squash.
module lq_tally #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [DEPTH-1:0] live_i,
  input  logic [SEQ_W-1:0] seq_i [DEPTH],
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic [CNT_W-1:0] commit_n_o,
  output logic [CNT_W-1:0] squash_n_o
);
  always_comb begin
    commit_n_o = '0;
    squash_n_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      // queue is age ordered, so eligible sets are a prefix / suffix
      commit_n_o = commit_n_o + CNT_W'(live_i[i] && (seq_i[i] <= commit_seq_i));
      squash_n_o = squash_n_o + CNT_W'(live_i[i] && (seq_i[i] >  squash_seq_i));
    end
  end
endmodule

// File: rtl/lq_scan.sv
// Oldest-first search for a younger load in the store's region.
module lq_scan #(
  parameter int DEPTH      = 8,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  head_i,
  input  logic [DEPTH-1:0]  live_i,
  input  logic [DEPTH-1:0]  addr_ok_i,
  input  logic [SEQ_W-1:0]  seq_i  [DEPTH],
  input  logic [ADDR_W-1:0] addr_i [DEPTH],
  input  logic [SEQ_W-1:0]  st_seq_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  logic [IDX_W-1:0] slot;
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    slot      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_i + IDX_W'(k);
      if (!hit_o && live_i[slot] && addr_ok_i[slot] && (seq_i[slot] > st_seq_i) &&
          (addr_i[slot][ADDR_W-1:REGION_LSB] == st_addr_i[ADDR_W-1:REGION_LSB])) begin
        hit_o     = 1'b1;
        hit_idx_o = slot;
      end
    end
  end
endmodule

// File: rtl/load_queue.sv
// DEPTH must be a power of two.
module load_queue #(
  parameter int DEPTH      = 8,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              lq_full_o,
  input  logic              exec_valid_i,
  input  logic [IDX_W-1:0]  exec_idx_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic              commit_valid_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  input  logic              squash_valid_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  input  logic              st_valid_i,
  input  logic [SEQ_W-1:0]  st_seq_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              viol_valid_o,
  output logic [IDX_W-1:0]  viol_idx_o,
  output logic [SEQ_W-1:0]  viol_seq_o,
  input  logic              viol_ack_i,
  input  logic [CNT_W-1:0]  sq_free_i,
  output logic [CNT_W-1:0]  disp_free_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [SEQ_W-1:0]  oldest_seq_o
);
  import lq_pkg::*;

  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  addr_ok_q;
  logic [CNT_W-1:0]  head_q, tail_q, count;
  logic [DEPTH-1:0]  live;
  logic [CNT_W-1:0]  commit_n, squash_n;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              viol_q;
  logic [IDX_W-1:0]  viol_idx_q;
  logic [SEQ_W-1:0]  viol_seq_q;
  lq_op_e            op;
  logic              alloc_go;
  logic [CNT_W-1:0]  lq_free, min_free;

  assign count    = tail_q - head_q;
  assign lq_full_o = (count == CNT_W'(DEPTH));

  lq_live #(.DEPTH(DEPTH)) u_live (
    .head_i (head_q[IDX_W-1:0]),
    .count_i(count),
    .live_o (live)
  );

  lq_tally #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_tally (
    .live_i      (live),
    .seq_i       (seq_q),
    .commit_seq_i(commit_seq_i),
    .squash_seq_i(squash_seq_i),
    .commit_n_o  (commit_n),
    .squash_n_o  (squash_n)
  );

  lq_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)) u_scan (
    .head_i   (head_q[IDX_W-1:0]),
    .live_i   (live),
    .addr_ok_i(addr_ok_q),
    .seq_i    (seq_q),
    .addr_i   (addr_q),
    .st_seq_i (st_seq_i),
    .st_addr_i(st_addr_i),
    .hit_o    (hit),
    .hit_idx_o(hit_idx)
  );

  always_comb begin
    if (squash_valid_i)      op = LQ_SQUASH;
    else if (commit_valid_i) op = LQ_COMMIT;
    else                     op = LQ_HOLD;
  end
  assign alloc_go = alloc_valid_i && !squash_valid_i && !lq_full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      case (op)
        LQ_SQUASH: tail_q <= tail_q - squash_n;
        LQ_COMMIT: begin
          head_q <= head_q + commit_n;
          tail_q <= tail_q + CNT_W'(alloc_go);
        end
        default:   tail_q <= tail_q + CNT_W'(alloc_go);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_ok_q <= '0;
    end else begin
      if (alloc_go) addr_ok_q[tail_q[IDX_W-1:0]] <= 1'b0;
      if (exec_valid_i && live[exec_idx_i]) addr_ok_q[exec_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_go) seq_q[tail_q[IDX_W-1:0]] <= alloc_seq_i;
    if (exec_valid_i && live[exec_idx_i]) addr_q[exec_idx_i] <= exec_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q     <= 1'b0;
      viol_idx_q <= '0;
      viol_seq_q <= '0;
    end else if (viol_q) begin
      if (viol_ack_i) viol_q <= 1'b0;
    end else if (st_valid_i && hit) begin
      viol_q     <= 1'b1;
      viol_idx_q <= hit_idx;
      viol_seq_q <= seq_q[hit_idx];
    end
  end

  assign lq_free     = CNT_W'(DEPTH) - count;
  assign min_free    = (lq_free < sq_free_i) ? lq_free : sq_free_i;
  assign disp_free_o = (min_free == '0) ? '0 : min_free - CNT_W'(1);

  assign alloc_idx_o  = tail_q[IDX_W-1:0];
  assign count_o      = count;
  assign oldest_seq_o = seq_q[head_q[IDX_W-1:0]];
  assign viol_valid_o = viol_q;
  assign viol_idx_o   = viol_idx_q;
  assign viol_seq_o   = viol_seq_q;
endmodule

// File: rtl/load_queue_chk.sv
module load_queue_chk #(
  parameter int DEPTH      = 8,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alloc_valid_i,
  input logic              lq_full_o,
  input logic              commit_valid_i,
  input logic              squash_valid_i,
  input logic              st_valid_i,
  input logic              viol_valid_o,
  input logic [IDX_W-1:0]  viol_idx_o,
  input logic [SEQ_W-1:0]  viol_seq_o,
  input logic              viol_ack_i,
  input logic [CNT_W-1:0]  sq_free_i,
  input logic [CNT_W-1:0]  disp_free_o,
  input logic [CNT_W-1:0]  count_o
);
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  a_r2_alloc_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !lq_full_o && !squash_valid_i && !commit_valid_i)
    |=> count_o == $past(count_o) + CNT_W'(1));

  a_r2_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lq_full_o && !squash_valid_i && !commit_valid_i) |=> lq_full_o);

  a_r4_squash_shrink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i |=> count_o <= $past(count_o));

  a_r5_needs_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_valid_o) |-> $past(st_valid_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && !viol_ack_i)
    |=> viol_valid_o && $stable(viol_idx_o) && $stable(viol_seq_o));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_valid_o && viol_ack_i) |=> !viol_valid_o);

  a_r9_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_free_o <= sq_free_i) && (disp_free_o < CNT_W'(DEPTH)));
endmodule

bind load_queue load_queue_chk #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_valid_i (alloc_valid_i),
  .lq_full_o     (lq_full_o),
  .commit_valid_i(commit_valid_i),
  .squash_valid_i(squash_valid_i),
  .st_valid_i    (st_valid_i),
  .viol_valid_o  (viol_valid_o),
  .viol_idx_o    (viol_idx_o),
  .viol_seq_o    (viol_seq_o),
  .viol_ack_i    (viol_ack_i),
  .sq_free_i     (sq_free_i),
  .disp_free_o   (disp_free_o),
  .count_o       (count_o)
);

// File: tb/load_queue_bench.sv
`timescale 1ns/1ps
module load_queue_bench;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 16;
  localparam int ADDR_W = 32;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0; logic [SEQ_W-1:0] alloc_seq = '0;
  logic [IDX_W-1:0] alloc_idx; logic full;
  logic exec_valid = 0; logic [IDX_W-1:0] exec_idx = '0; logic [ADDR_W-1:0] exec_addr = '0;
  logic commit_valid = 0; logic [SEQ_W-1:0] commit_seq = '0;
  logic squash_valid = 0; logic [SEQ_W-1:0] squash_seq = '0;
  logic st_valid = 0; logic [SEQ_W-1:0] st_seq = '0; logic [ADDR_W-1:0] st_addr = '0;
  logic viol_valid; logic [IDX_W-1:0] viol_idx; logic [SEQ_W-1:0] viol_seq;
  logic viol_ack = 0;
  logic [CNT_W-1:0] sq_free = CNT_W'(8);
  logic [CNT_W-1:0] disp_free, count;
  logic [SEQ_W-1:0] oldest_seq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_q[$];
  logic prev_viol = 0;

  always #10 clk = ~clk;

  load_queue u_load_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_seq_i(alloc_seq), .alloc_idx_o(alloc_idx), .lq_full_o(full),
    .exec_valid_i(exec_valid), .exec_idx_i(exec_idx), .exec_addr_i(exec_addr),
    .commit_valid_i(commit_valid), .commit_seq_i(commit_seq),
    .squash_valid_i(squash_valid), .squash_seq_i(squash_seq),
    .st_valid_i(st_valid), .st_seq_i(st_seq), .st_addr_i(st_addr),
    .viol_valid_o(viol_valid), .viol_idx_o(viol_idx), .viol_seq_o(viol_seq), .viol_ack_i(viol_ack),
    .sq_free_i(sq_free), .disp_free_o(disp_free), .count_o(count), .oldest_seq_o(oldest_seq)
  );

  task automatic check(string req, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_alloc(int s);
    alloc_valid = 1; alloc_seq = SEQ_W'(s); tick(); alloc_valid = 0;
  endtask

  task automatic do_exec(int i, int a);
    exec_valid = 1; exec_idx = IDX_W'(i); exec_addr = ADDR_W'(a); tick(); exec_valid = 0;
  endtask

  // driver: pushes the expected violator (idx*65536+seq) when a hit is expected
  task automatic do_store(int s, int a, bit expect_hit, int eidx, int eseq);
    if (expect_hit) exp_q.push_back(eidx * 65536 + eseq);
    st_valid = 1; st_seq = SEQ_W'(s); st_addr = ADDR_W'(a); tick(); st_valid = 0;
  endtask

  task automatic do_ack();
    viol_ack = 1; tick(); viol_ack = 0;
  endtask

  // monitor: compares each new report against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (viol_valid && !prev_viol) begin
        n_run++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R6 unexpected violation actual=%0d/%0d expected=none", viol_idx, viol_seq);
        end else begin
          int e;
          e = exp_q.pop_front();
          if ({16'(viol_idx), viol_seq} != 32'(e)) begin
            n_fail++;
            $display("FAIL R5 R7 violator actual=%0d/%0d expected=%0d/%0d",
                     viol_idx, viol_seq, e / 65536, e % 65536);
          end
        end
      end
      prev_viol = viol_valid;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1
    check("R1 count", int'(count), 0);
    check("R1 full", int'(full), 0);
    check("R1 viol", int'(viol_valid), 0);
    check("R9 free empty", int'(disp_free), 7);

    // R2
    for (int s = 10; s < 14; s++) do_alloc(s);
    check("R2 count", int'(count), 4);
    check("R2 idx", int'(alloc_idx), 4);
    check("R3 oldest", int'(oldest_seq), 10);

    do_exec(1, 'h1234);
    do_exec(2, 'h12FF);
    do_exec(3, 'h5600);
    do_exec(0, 'h1200);

    // R5 R7: seq10 equal (skipped), 11 and 12 match; oldest 11
    do_store(10, 'h1210, 1, 1, 11);
    check("R5 viol", int'(viol_valid), 1);
    check("R5 idx", int'(viol_idx), 1);
    // R8: pending blocks new check
    do_store(12, 'h5600, 0, 0, 0);
    check("R8 held idx", int'(viol_idx), 1);
    check("R8 held seq", int'(viol_seq), 11);
    viol_ack = 1; st_valid = 1; st_seq = 16'd12; st_addr = 32'h5600; tick();
    viol_ack = 0; st_valid = 0;
    check("R8 cleared", int'(viol_valid), 0);
    tick();
    check("R8 ack cycle check ignored", int'(viol_valid), 0);
    do_store(12, 'h5600, 1, 3, 13);
    check("R5 second", int'(viol_seq), 13);
    do_ack();

    // R6
    do_alloc(14);
    do_store(9, 'h0010, 0, 0, 0);
    check("R6 no addr", int'(viol_valid), 0);
    do_store(9, 'h1300, 0, 0, 0);
    check("R6 other region", int'(viol_valid), 0);
    do_store(13, 'h5600, 0, 0, 0);
    check("R6 equal seq", int'(viol_valid), 0);

    // R3
    commit_valid = 1; commit_seq = 16'd11; tick(); commit_valid = 0;
    check("R3 count", int'(count), 3);
    check("R3 oldest", int'(oldest_seq), 12);
    commit_valid = 1; commit_seq = 16'd5; tick(); commit_valid = 0;
    check("R3 none", int'(count), 3);

    // R4 with simultaneous allocate
    squash_valid = 1; squash_seq = 16'd12; alloc_valid = 1; alloc_seq = 16'd99; tick();
    squash_valid = 0; alloc_valid = 0;
    check("R4 count", int'(count), 1);
    check("R4 idx", int'(alloc_idx), 3);
    check("R4 oldest", int'(oldest_seq), 12);
    sq_free = CNT_W'(3); #1;
    check("R9 store bound", int'(disp_free), 2);

    // R2 full and wrap
    for (int s = 20; s < 27; s++) do_alloc(s);
    check("R2 full", int'(full), 1);
    check("R2 wrap idx", int'(alloc_idx), 2);
    sq_free = CNT_W'(8); #1;
    check("R9 floor", int'(disp_free), 0);
    do_alloc(30);
    check("R2 ignored", int'(count), 8);

    // R7 across wrap: seq25 at slot0, seq23 at slot6; oldest is 23
    do_exec(0, 'h7700);
    do_exec(6, 'h77AA);
    do_store(21, 'h7701, 1, 6, 23);
    check("R7 wrap idx", int'(viol_idx), 6);
    do_ack();

    commit_valid = 1; commit_seq = 16'd30; tick(); commit_valid = 0;
    check("R3 drain", int'(count), 0);
    check("R2 not full", int'(full), 0);

    tick();
    check("R5 all reports seen", exp_q.size(), 0);
    finish_run();
  end
endmodule